// File: doc/BRIEF.md
# Self-Routing Register Hub

This block is one hub in a chain of hubs that carries 64-bit register reads and writes from a requester to a target module. Each request has a 32-bit address. The upper 18 bits hold six 3-bit channel numbers, and the lower 14 bits hold a register index inside the target. The hub reads the top channel number as its output port and removes that number by shifting the 18-bit field left by three bits, with zeros filling the low end. It then passes the request on with the new address. Each later hub therefore finds its own channel number at the top of the address, and a path through up to six hubs fits in the address itself.

Channel 0 selects the hub's own small register file. Channels 1 to 7 lead to attached modules or to the next hub. A parameter mask tells the hub which of those channels have something attached. A request to an empty channel completes at once with an error flag, so it can never stall the requester. A local access to an unimplemented index also completes: a write to it is dropped, and a read of it returns zero. The hub handles one transaction at a time. It accepts no new request until the current response has been handed back upstream.

Top module: `msr_hop_router`

## Requirements
- R1: The output channel is address bits [31:29]. A request on channel c (1..7) raises only bit c-1 of `dn_req_valid`.
- R2: A forwarded address equals {addr[28:14], 3'b000, addr[13:0]}. The write flag and the 64-bit write data pass through unchanged.
- R3: Channel 0 accesses a file of NREG 64-bit registers (default 4) at indices 0..NREG-1. A read returns the last value written, with `up_rsp_err` = 0.
- R4: A channel 0 access at an index of NREG or above completes with `up_rsp_err` = 0. A write there changes no register, and a read there returns zero.
- R5: A request to a channel whose ATTACHED bit is clear (by default only channel 7) completes with `up_rsp_err` = 1 and read data zero. It raises no downstream request.
- R6: The read data and error flag of a downstream response are returned upstream unchanged.
- R7: Only one transaction is in flight. `up_req_ready` stays low from the acceptance of a request until the upstream response handshake completes. A request held valid during that handshake is accepted on the following clock edge at the earliest.
- R8: `up_rsp_valid` and its data stay stable until `up_rsp_ready`. `dn_req_valid` and `dn_req_addr` stay stable until the chosen channel's ready is high.
- R9: After reset, `up_req_ready` = 1, no valid output is raised, and every local register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Hub can accept a request |
| up_req_write | input | 1 | 1 = write, 0 = read |
| up_req_addr | input | 32 | Routing field and index |
| up_req_wdata | input | 64 | Write data |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_ready | input | 1 | Requester takes the response |
| up_rsp_rdata | output | 64 | Read data |
| up_rsp_err | output | 1 | Empty channel or downstream error |
| dn_req_valid | output | 7 | Per-channel request valid, bit i = channel i+1 |
| dn_req_ready | input | 7 | Per-channel request ready |
| dn_req_write | output | 1 | Forwarded write flag |
| dn_req_addr | output | 32 | Forwarded, shifted address |
| dn_req_wdata | output | 64 | Forwarded write data |
| dn_rsp_valid | input | 7 | Per-channel response valid |
| dn_rsp_ready | output | 7 | Per-channel response ready |
| dn_rsp_rdata | input | 448 | Per-channel read data, slice i = channel i+1 |
| dn_rsp_err | input | 7 | Per-channel error flag |

## Verification
Two events can fall on the same clock edge: the upstream response handshake and a new request waiting upstream. The bench holds a second request valid while it withholds `up_rsp_ready`. It then releases the ready signal. It checks that `up_req_ready` is low on the handshake edge and high one cycle later, and that the second response carries the data for its own index. In a separate case, a downstream channel withholds ready while the forwarded request must hold still.

// File: rtl/msr_hop_router.sv
module msr_hop_router #(
  parameter int NREG = 4,
  parameter logic [6:0] ATTACHED = 7'b0111111
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_req_valid,
  output logic         up_req_ready,
  input  logic         up_req_write,
  input  logic [31:0]  up_req_addr,
  input  logic [63:0]  up_req_wdata,
  output logic         up_rsp_valid,
  input  logic         up_rsp_ready,
  output logic [63:0]  up_rsp_rdata,
  output logic         up_rsp_err,
  output logic [6:0]   dn_req_valid,
  input  logic [6:0]   dn_req_ready,
  output logic         dn_req_write,
  output logic [31:0]  dn_req_addr,
  output logic [63:0]  dn_req_wdata,
  input  logic [6:0]   dn_rsp_valid,
  output logic [6:0]   dn_rsp_ready,
  input  logic [447:0] dn_rsp_rdata,
  input  logic [6:0]   dn_rsp_err
);
  localparam int RW = $clog2(NREG);
  localparam logic [7:0] LIVE = {ATTACHED, 1'b0};

  typedef enum logic [1:0] {IDLE, FWD, WAIT, RESP} st_t;
  st_t st;

  logic [2:0]  port_q;
  logic [31:0] addr_q;
  logic        write_q;
  logic [63:0] wdata_q;
  logic [63:0] rsp_data;
  logic        rsp_err;
  logic [63:0] regs [NREG];

  wire  [2:0] in_port = up_req_addr[31:29];
  wire        accept  = up_req_valid && up_req_ready;
  wire        loc_hit = up_req_addr[13:0] < 14'(NREG);
  wire  [RW-1:0] loc_idx = up_req_addr[RW-1:0];
  wire  [2:0] pidx = port_q - 3'd1;
  wire  [6:0] psel = 7'd1 << pidx;

  assign up_req_ready = (st == IDLE);
  assign up_rsp_valid = (st == RESP);
  assign up_rsp_rdata = rsp_data;
  assign up_rsp_err   = rsp_err;
  assign dn_req_valid = (st == FWD)  ? psel : 7'd0;
  assign dn_rsp_ready = (st == WAIT) ? psel : 7'd0;
  assign dn_req_addr  = addr_q;
  assign dn_req_write = write_q;
  assign dn_req_wdata = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= IDLE;
      port_q   <= '0;
      addr_q   <= '0;
      write_q  <= 1'b0;
      wdata_q  <= '0;
      rsp_data <= '0;
      rsp_err  <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      case (st)
        IDLE: if (accept) begin
          port_q  <= in_port;
          addr_q  <= {up_req_addr[28:14], 3'b000, up_req_addr[13:0]};
          write_q <= up_req_write;
          wdata_q <= up_req_wdata;
          if (in_port == 3'd0) begin
            rsp_err  <= 1'b0;
            rsp_data <= (!up_req_write && loc_hit) ? regs[loc_idx] : 64'd0;
            if (up_req_write && loc_hit) regs[loc_idx] <= up_req_wdata;
            st <= RESP;
          end else if (!LIVE[in_port]) begin
            rsp_err  <= 1'b1;
            rsp_data <= '0;
            st <= RESP;
          end else begin
            st <= FWD;
          end
        end
        FWD:  if (dn_req_ready[pidx]) st <= WAIT;
        WAIT: if (dn_rsp_valid[pidx]) begin
          rsp_data <= dn_rsp_rdata[int'(pidx)*64 +: 64];
          rsp_err  <= dn_rsp_err[pidx];
          st <= RESP;
        end
        RESP: if (up_rsp_ready) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  assert_one_port_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_req_valid));

  assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && LIVE[in_port]) |=>
      dn_req_addr == {$past(up_req_addr[28:14]), 3'b000, $past(up_req_addr[13:0])});

  assert_empty_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_port != 3'd0 && !LIVE[in_port]) |=>
      up_rsp_valid && up_rsp_err && dn_req_valid == 7'd0);

  assert_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    up_rsp_valid |-> !up_req_ready);

  assert_hold_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid && !up_rsp_ready) |=>
      up_rsp_valid && $stable(up_rsp_rdata) && $stable(up_rsp_err));

  assert_hold_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dn_req_valid & ~dn_req_ready)) |=>
      $stable(dn_req_valid) && $stable(dn_req_addr));
endmodule

// File: tb/msr_hop_router_bench.sv
module msr_hop_router_bench;
  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic         up_req_valid = 0, up_req_write = 0, up_rsp_ready = 1;
  logic [31:0]  up_req_addr = 0;
  logic [63:0]  up_req_wdata = 0;
  logic         up_req_ready, up_rsp_valid, up_rsp_err;
  logic [63:0]  up_rsp_rdata;
  logic [6:0]   dn_req_valid, dn_rsp_ready;
  logic [6:0]   dn_req_ready = 7'h7F;
  logic         dn_req_write;
  logic [31:0]  dn_req_addr;
  logic [63:0]  dn_req_wdata;
  logic [6:0]   dn_rsp_valid = 0, dn_rsp_err = 0;
  logic [447:0] dn_rsp_rdata = 0;

  msr_hop_router u_msr_hop_router (.*);

  int total = 0, bad = 0, cycles = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // downstream responder model
  logic        seen, pend, taking;
  int          seen_port, delay_cnt;
  logic [31:0] seen_addr;
  logic        seen_write;
  logic [63:0] seen_wdata;
  initial begin seen = 0; pend = 0; taking = 0; seen_port = 0; delay_cnt = 0; end

  function automatic logic [63:0] rsp_word(input int p, input logic [31:0] a);
    return {29'd0, 3'(p), a};
  endfunction

  always @(negedge clk) begin
    if (taking) begin dn_rsp_valid = 0; taking = 0; end
    if (|(dn_req_valid & dn_req_ready)) begin
      for (int i = 0; i < 7; i++) if (dn_req_valid[i]) seen_port = i + 1;
      seen = 1; seen_addr = dn_req_addr; seen_write = dn_req_write;
      seen_wdata = dn_req_wdata; pend = 1; delay_cnt = 1;
    end else if (pend) begin
      if (delay_cnt > 0) delay_cnt--;
      else begin
        dn_rsp_rdata[(seen_port-1)*64 +: 64] = rsp_word(seen_port, seen_addr);
        dn_rsp_err[seen_port-1] = (seen_addr[13:0] == 14'h3FFF);
        dn_rsp_valid = 7'd1 << (seen_port - 1);
        pend = 0;
      end
    end
    if (|(dn_rsp_valid & dn_rsp_ready)) taking = 1;
  end

  task automatic txn(input logic w, input logic [31:0] a, input logic [63:0] d,
                     output logic [63:0] rd, output logic er);
    @(negedge clk);
    up_req_valid = 1; up_req_write = w; up_req_addr = a; up_req_wdata = d;
    while (!up_req_ready) @(negedge clk);
    @(negedge clk);
    up_req_valid = 0;
    while (!(up_rsp_valid && up_rsp_ready)) @(negedge clk);
    rd = up_rsp_rdata; er = up_rsp_err;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic        w;
    logic [31:0] addr;
    logic [63:0] wdata;
    logic [2:0]  exp_port;
    logic        exp_err;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 32'h0000_0000, 64'h1111_2222_3333_4444, 3'd0, 1'b0},
    '{1'b1, 32'h0000_0003, 64'hDEAD_BEEF_0000_0005, 3'd0, 1'b0},
    '{1'b1, 32'h0000_0009, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0, 1'b0},
    '{1'b0, 32'h0000_0009, 64'd0,                  3'd0, 1'b0},
    '{1'b0, 32'h0000_0000, 64'd0,                  3'd0, 1'b0},
    '{1'b0, 32'h0000_0003, 64'd0,                  3'd0, 1'b0},
    '{1'b0, 32'h0000_0001, 64'd0,                  3'd0, 1'b0},
    '{1'b1, 32'h4C00_1234, 64'h0123_4567_89AB_CDEF, 3'd2, 1'b0},
    '{1'b0, 32'hA123_4567, 64'd0,                  3'd5, 1'b0},
    '{1'b0, 32'hE000_0010, 64'd0,                  3'd7, 1'b1},
    '{1'b1, 32'h2000_3FFF, 64'h5555_0000_AAAA_0000, 3'd1, 1'b1},
    '{1'b0, 32'hD555_0ABC, 64'd0,                  3'd6, 1'b0}
  };

  logic [63:0] shadow [4];
  logic [63:0] rd, exp_rd;
  logic        er;

  initial begin
    for (int i = 0; i < 4; i++) shadow[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    check("R9 ready", up_req_ready, 1);
    check("R9 rsp_valid", up_rsp_valid, 0);
    check("R9 dn_req_valid", dn_req_valid, 0);

    for (int v = 0; v < NV; v++) begin
      vec_t t = VEC[v];
      seen = 0;
      txn(t.w, t.addr, t.wdata, rd, er);
      if (t.exp_port == 0) begin
        // R3 / R4 local registers
        if (t.addr[13:0] < 4) begin
          if (t.w) shadow[t.addr[1:0]] = t.wdata;
          exp_rd = t.w ? 64'd0 : shadow[t.addr[1:0]];
          check("R3 local rdata", rd, exp_rd);
        end else begin
          check("R4 unimplemented rdata", rd, 0);
        end
        check("R3 local err", er, 0);
        check("R1 no downstream for local", seen, 0);
      end else if (t.exp_port == 7) begin
        check("R5 empty err", er, 1);
        check("R5 empty rdata", rd, 0);
        check("R5 no downstream", seen, 0);
      end else begin
        check("R1 port", seen_port, t.exp_port);
        check("R2 addr", seen_addr, {t.addr[28:14], 3'b000, t.addr[13:0]});
        check("R2 write flag", seen_write, t.w);
        check("R2 wdata", seen_wdata, t.wdata);
        check("R6 rdata", rd, rsp_word(t.exp_port, {t.addr[28:14], 3'b000, t.addr[13:0]}));
        check("R6 err", er, t.exp_err);
      end
    end

    // R9: untouched register still zero after reset
    txn(0, 32'h0000_0002, 0, rd, er);
    check("R9 reg2 zero", rd, 0);

    // R7: new request held during upstream response handshake
    up_rsp_ready = 0;
    @(negedge clk);
    up_req_valid = 1; up_req_write = 0; up_req_addr = 32'h0000_0000;
    while (!up_req_ready) @(negedge clk);
    @(negedge clk);
    up_req_addr = 32'h0000_0003;
    repeat (3) begin
      @(negedge clk);
      check("R7 ready low while response pending", up_req_ready, 0);
      check("R8 response held", up_rsp_valid, 1);
    end
    check("R8 response data", up_rsp_rdata, shadow[0]);
    up_rsp_ready = 1;
    check("R7 ready low at handshake edge", up_req_ready, 0);
    @(negedge clk);
    check("R7 ready one cycle after handshake", up_req_ready, 1);
    @(negedge clk);
    up_req_valid = 0;
    while (!up_rsp_valid) @(negedge clk);
    check("R7 second response data", up_rsp_rdata, shadow[3]);
    @(negedge clk);

    // R8: downstream request held while channel stalls
    dn_req_ready = 7'd0;
    seen = 0;
    fork
      txn(0, 32'h8000_0042, 0, rd, er);
      begin
        repeat (3) @(negedge clk);
        repeat (3) begin
          @(negedge clk);
          check("R8 dn_req_valid held", dn_req_valid, 7'b0001000);
          check("R8 dn_req_addr held", dn_req_addr, 32'h0000_0042);
        end
        dn_req_ready = 7'h7F;
      end
    join
    check("R1 stalled request port", seen_port, 4);
    check("R6 stalled rdata", rd, rsp_word(4, 32'h0000_0042));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule